// File: doc/BRIEF.md
# Clock Domain Sleep/Wake Controller

This block decides, for a single clock domain, whether the domain's root clock runs or is gated off. Software picks one of four transition modes through a 2-bit field. Two of them force the domain: one forces sleep and one forces wakeup. One mode forbids sleep but still lets a hardware wakeup request bring a gated domain back. The last, the default, is a hardware-automatic mode. In that mode an idle monitor watches the activity strobe from the domain's initiator port and puts the domain to sleep once no activity has been seen for a programmable number of prescaler ticks.

The block drives a clock-enable output to the gating cell. It reports a clock-activity bit that reads 0 only when the clock is definitely stopped. Gating and ungating each take a fixed two-cycle sequence, and the activity bit stays 1 throughout both. A warm reset returns the software-visible settings to their defaults. It leaves the clock state and the activity bit as they were.

Top module: `cdom_sleep_ctrl`

## Requirements
- R1: Register at address 0 holds the mode in bits [1:0] and the read-only activity bit in bit 4. Register at address 1 holds the window size in bits [3:0]. All other bits read 0 and ignore writes, and writes to bit 4 have no effect.
- R2: After cold reset the mode reads 3 (automatic), the window reads 4, and the domain is running with clk_en = 1 and clk_active = 1.
- R3: clk_active (and register bit 4) is 0 only while the domain is gated. It is 1 while running and during both cycles of a gating or ungating sequence.
- R4: Gating and ungating each last exactly two cycles. clk_en stays 1 during gating and goes 0 when the domain reaches the gated state. It stays 0 during ungating and goes 1 when the domain reaches the running state.
- R5: In mode 3, while the domain runs, each prescaler tick without activity advances an idle count, and an activity strobe clears the count. Gating starts on a cycle with no activity once the count has reached the window size. A window of 0 gates on the first idle cycle.
- R6: In mode 3 a gated domain starts ungating on an activity strobe or on a hardware wakeup request.
- R7: In mode 1 a running domain starts gating on the next clock edge. A gated domain stays gated whatever the activity and wakeup inputs do.
- R8: In mode 2 a gated domain starts ungating, and a running domain never gates.
- R9: In mode 0 a running domain never gates. A gated domain ungates on a hardware wakeup request but not on an activity strobe.
- R10: Warm reset sets the mode to 3 and the window to 4 and clears the idle count. It does not return the clock state or the activity bit to their reset values.
- R11: A gating or ungating sequence, once started, completes even if the mode changes during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Cold reset, synchronous, active low |
| warm_rst_n | input | 1 | Warm reset, synchronous, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| bus_act | input | 1 | Initiator-port activity strobe |
| presc_tick | input | 1 | Time-unit tick from the external prescaler |
| hw_wake | input | 1 | Hardware wakeup request |
| clk_en | output | 1 | Enable to the domain's clock gate |
| clk_active | output | 1 | Clock activity status |

## Verification
On every cycle, the embedded assertions check four things: reserved read bits are zero, a forced-sleep or sleep-forbidden mode never makes the wrong move, a gating sequence is never cut short, and an activity strobe always clears the idle count. The assertions also check that warm reset restores the defaults. Other behaviour appears only over a scenario, so the bench must show it. This covers the exact cycle on which an idle window expires, wakeup from the gated state in each mode, a transition that completes across a mode change, and a warm reset that leaves a gated domain gated. The bench compares every output with a cycle model on every cycle of a long random run and in the directed cases.

// File: rtl/cdom_pkg.sv
// Shared types for the clock domain sleep/wake controller.
// Assumes the mode encoding below is the software-visible one.
package cdom_pkg;

    typedef enum logic [1:0] {
        MODE_NOSLP  = 2'd0,
        MODE_SWSLP  = 2'd1,
        MODE_SWWAKE = 2'd2,
        MODE_AUTO   = 2'd3
    } cdom_mode_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WAKE  = 2'd1,
        ST_ON    = 2'd2,
        ST_SLEEP = 2'd3
    } cdom_state_e;

endpackage

// File: rtl/cdom_regs.sv
// Register file: mode field, window field and a read mux that also
// returns the activity status. Assumes a single-cycle write strobe and
// that warm reset has priority over a write in the same cycle.
module cdom_regs
    import cdom_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int WIN_W   = 4,
    parameter int WIN_RST = 4,
    parameter int ACT_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              warm_rst_n,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              act_in,
    output logic [DATA_W-1:0] rdata,
    output cdom_mode_e        mode,
    output logic [WIN_W-1:0]  window
);
    localparam logic [WIN_W-1:0] WIN_DEF = WIN_W'(WIN_RST);
    localparam logic [DATA_W-1:0] MASK0 = (DATA_W'(1) << ACT_BIT) | DATA_W'(3);
    localparam logic [DATA_W-1:0] MASK1 = DATA_W'((1 << WIN_W) - 1);

    cdom_mode_e       mode_q;
    logic [WIN_W-1:0] win_q;

    // Hold the mode and window fields; either reset restores defaults.
    always_ff @(posedge clk) begin
        if (!rst_n || !warm_rst_n) begin
            mode_q <= MODE_AUTO;
            win_q  <= WIN_DEF;
        end else if (wr_en) begin
            if (!addr) mode_q <= cdom_mode_e'(wdata[1:0]);
            else       win_q  <= wdata[WIN_W-1:0];
        end
    end

    // Assemble read data; unused bits stay zero.
    always_comb begin
        rdata = '0;
        if (!addr) begin
            rdata[1:0]     = mode_q;
            rdata[ACT_BIT] = act_in;
        end else begin
            rdata[WIN_W-1:0] = win_q;
        end
    end

    assign mode   = mode_q;
    assign window = win_q;

    // R1
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & ~(addr ? MASK1 : MASK0)) == '0);

    // R10
    warm_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !warm_rst_n |=> (mode_q == MODE_AUTO && win_q == WIN_DEF));
endmodule

// File: rtl/cdom_idle_mon.sv
// Idle-window monitor: counts prescaler ticks with no activity while
// enabled and flags when the window has elapsed. Assumes the window may
// change at any time; the count saturates at the current window.
module cdom_idle_mon #(
    parameter int WIN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             warm_rst_n,
    input  logic             enable,
    input  logic             bus_act,
    input  logic             tick,
    input  logic [WIN_W-1:0] window,
    output logic             idle_done
);
    logic [WIN_W-1:0] cnt_q;

    // Advance on idle ticks, restart on activity or when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !warm_rst_n || !enable || bus_act) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q < window)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign idle_done = enable && !bus_act && (cnt_q >= window);

    // R5
    act_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_act |=> (cnt_q == '0));
endmodule

// File: rtl/cdom_clk_fsm.sv
// Domain clock state machine: running, gating, gated, ungating. Each
// transition lasts TRANS_CYC cycles and cannot be aborted. Assumes
// TRANS_CYC >= 1 and is unaffected by warm reset by design.
module cdom_clk_fsm
    import cdom_pkg::*;
#(
    parameter int TRANS_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  cdom_mode_e mode,
    input  logic       idle_done,
    input  logic       bus_act,
    input  logic       hw_wake,
    output logic       mon_en,
    output logic       clk_en,
    output logic       clk_active
);
    localparam int TC_W = (TRANS_CYC > 1) ? $clog2(TRANS_CYC) : 1;
    localparam logic [TC_W-1:0] TC_LAST = TC_W'(TRANS_CYC - 1);

    cdom_state_e     state_q, state_d;
    logic [TC_W-1:0] tcnt_q, tcnt_d;
    logic            go_sleep, go_wake;

    // Decide whether the current mode asks for a sleep or wake move.
    always_comb begin
        go_sleep = (mode == MODE_SWSLP) || (mode == MODE_AUTO && idle_done);
        unique case (mode)
            MODE_NOSLP:  go_wake = hw_wake;
            MODE_SWSLP:  go_wake = 1'b0;
            MODE_SWWAKE: go_wake = 1'b1;
            default:     go_wake = bus_act || hw_wake;
        endcase
    end

    // Next-state logic including transition cycle counting.
    always_comb begin
        state_d = state_q;
        tcnt_d  = tcnt_q;
        unique case (state_q)
            ST_ON: if (go_sleep) begin
                state_d = ST_SLEEP;
                tcnt_d  = '0;
            end
            ST_SLEEP: if (tcnt_q == TC_LAST) state_d = ST_OFF;
                      else tcnt_d = tcnt_q + 1'b1;
            ST_OFF: if (go_wake) begin
                state_d = ST_WAKE;
                tcnt_d  = '0;
            end
            default: if (tcnt_q == TC_LAST) state_d = ST_ON;
                     else tcnt_d = tcnt_q + 1'b1;
        endcase
    end

    // State register; cold reset leaves the domain running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ON;
            tcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            tcnt_q  <= tcnt_d;
        end
    end

    assign mon_en     = (state_q == ST_ON) && (mode == MODE_AUTO);
    assign clk_en     = (state_q == ST_ON) || (state_q == ST_SLEEP);
    assign clk_active = (state_q != ST_OFF);

    // R7
    sw_sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && mode == MODE_SWSLP) |=> (state_q == ST_OFF));

    // R8
    no_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ON && (mode == MODE_NOSLP || mode == MODE_SWWAKE))
        |=> (state_q == ST_ON));

    // R9
    nosleep_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && mode == MODE_NOSLP && !hw_wake)
        |=> (state_q == ST_OFF));

    // R4
    gate_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && tcnt_q != TC_LAST) |=> (state_q == ST_SLEEP));

    // R4
    ungate_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKE && tcnt_q != TC_LAST) |=> (state_q == ST_WAKE));
endmodule

// File: rtl/cdom_sleep_ctrl.sv
// Top of the clock domain sleep/wake controller: ties the register file,
// the idle-window monitor and the clock state machine together.
// Assumes all inputs are synchronous to clk.
module cdom_sleep_ctrl
    import cdom_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int WIN_W     = 4,
    parameter int WIN_RST   = 4,
    parameter int ACT_BIT   = 4,
    parameter int TRANS_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              warm_rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              bus_act,
    input  logic              presc_tick,
    input  logic              hw_wake,
    output logic              clk_en,
    output logic              clk_active
);
    cdom_mode_e       mode;
    logic [WIN_W-1:0] window;
    logic             mon_en;
    logic             idle_done;

    cdom_regs #(
        .DATA_W (DATA_W),
        .WIN_W  (WIN_W),
        .WIN_RST(WIN_RST),
        .ACT_BIT(ACT_BIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .warm_rst_n(warm_rst_n),
        .wr_en     (reg_wr_en),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .act_in    (clk_active),
        .rdata     (reg_rdata),
        .mode      (mode),
        .window    (window)
    );

    cdom_idle_mon #(
        .WIN_W(WIN_W)
    ) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .warm_rst_n(warm_rst_n),
        .enable    (mon_en),
        .bus_act   (bus_act),
        .tick      (presc_tick),
        .window    (window),
        .idle_done (idle_done)
    );

    cdom_clk_fsm #(
        .TRANS_CYC(TRANS_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .idle_done (idle_done),
        .bus_act   (bus_act),
        .hw_wake   (hw_wake),
        .mon_en    (mon_en),
        .clk_en    (clk_en),
        .clk_active(clk_active)
    );
endmodule

// File: tb/cdom_sleep_ctrl_tb.sv
// Bench: directed corner cases plus seeded random stimulus, every cycle
// compared against a cycle model written from the requirements.
module cdom_sleep_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0, warm_rst_n = 1'b1;
    logic        reg_wr_en = 1'b0, reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bus_act = 1'b0, presc_tick = 1'b0, hw_wake = 1'b0;
    logic        clk_en, clk_active;

    int checks = 0, errors = 0;

    // model state: 0 gated, 1 ungating, 2 running, 3 gating
    int m_st, m_tc, m_cnt;
    logic [1:0] m_mode;
    logic [3:0] m_win;

    always #2 clk = ~clk;

    cdom_sleep_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .warm_rst_n(warm_rst_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .bus_act(bus_act), .presc_tick(presc_tick),
        .hw_wake(hw_wake), .clk_en(clk_en), .clk_active(clk_active)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rdata(logic a);
        logic [31:0] r = '0;
        if (!a) begin
            r[1:0] = m_mode;
            r[4]   = (m_st != 0);
        end else begin
            r[3:0] = m_win;
        end
        return r;
    endfunction

    // Model of one clock edge with the currently driven inputs.
    task automatic model_edge();
        int nst = m_st, ntc = m_tc, ncnt = m_cnt;
        logic [1:0] nmode = m_mode;
        logic [3:0] nwin = m_win;
        logic idle, wake;
        idle = (m_st == 2) && (m_mode == 2'd3) && !bus_act && (m_cnt >= m_win);
        if (!warm_rst_n) begin nmode = 2'd3; nwin = 4'd4; end
        else if (reg_wr_en) begin
            if (!reg_addr) nmode = reg_wdata[1:0]; else nwin = reg_wdata[3:0];
        end
        if (!warm_rst_n || !(m_st == 2 && m_mode == 2'd3) || bus_act) ncnt = 0;
        else if (presc_tick && m_cnt < m_win) ncnt = m_cnt + 1;
        wake = (m_mode == 2'd2) || (m_mode == 2'd0 && hw_wake) ||
               (m_mode == 2'd3 && (bus_act || hw_wake));
        case (m_st)
            2: if (m_mode == 2'd1 || idle) begin nst = 3; ntc = 0; end
            3: if (m_tc == 1) nst = 0; else ntc = m_tc + 1;
            0: if (wake) begin nst = 1; ntc = 0; end
            default: if (m_tc == 1) nst = 2; else ntc = m_tc + 1;
        endcase
        m_st = nst; m_tc = ntc; m_cnt = ncnt; m_mode = nmode; m_win = nwin;
    endtask

    // Compare outputs with the model, drive one cycle of inputs, advance.
    task automatic step(logic wr, logic a, logic [31:0] wd, logic ba,
                        logic tk, logic hw, logic warm);
        check("R4 clk_en", {31'd0, clk_en}, {31'd0, (m_st == 2 || m_st == 3)});
        check("R3 clk_active", {31'd0, clk_active}, {31'd0, (m_st != 0)});
        check("R1 rdata", reg_rdata, exp_rdata(reg_addr));
        reg_wr_en = wr; reg_addr = a; reg_wdata = wd;
        bus_act = ba; presc_tick = tk; hw_wake = hw; warm_rst_n = ~warm;
        model_edge();
        @(posedge clk);
        @(negedge clk);
        reg_wr_en = 1'b0; bus_act = 1'b0; presc_tick = 1'b0;
        hw_wake = 1'b0; warm_rst_n = 1'b1;
    endtask

    task automatic idle_steps(int n, logic tk);
        for (int i = 0; i < n; i++) step(0, reg_addr, 0, 0, tk, 0, 0);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_st = 2; m_tc = 0; m_cnt = 0; m_mode = 2'd3; m_win = 4'd4;

        // R2 reset state
        check("R2 clk_en", {31'd0, clk_en}, 32'd1);
        check("R2 clk_active", {31'd0, clk_active}, 32'd1);
        check("R2 mode", reg_rdata, 32'h0000_0013);
        reg_addr = 1'b1; #0;
        check("R2 window", reg_rdata, 32'd4);

        // R1 reserved bits ignore writes, bit 4 not writable
        step(1, 1, 32'hFFFF_FFF2, 1, 0, 0, 0);
        check("R1 window wr", reg_rdata, 32'd2);
        step(1, 0, 32'hFFFF_FFE3, 1, 0, 0, 0);
        check("R1 ctrl wr", reg_rdata, 32'h0000_0013);

        // R5 activity every cycle keeps the domain running
        for (int i = 0; i < 12; i++) step(0, 0, 0, 1, 1, 0, 0);
        check("R5 busy stays on", {31'd0, clk_active}, 32'd1);
        // R5 window 2: two idle ticks then gating (2 cycles) then gated
        idle_steps(2, 1);
        check("R5 still on at window", {31'd0, clk_en}, 32'd1);
        idle_steps(1, 1);
        check("R4 gating keeps clk_en", {31'd0, clk_en}, 32'd1);
        idle_steps(2, 1);
        check("R5 gated after window", {31'd0, clk_active}, 32'd0);

        // R6 activity wakes in automatic mode, ungating lasts two cycles
        step(0, 0, 0, 1, 0, 0, 0);
        check("R4 ungating clk_en", {31'd0, clk_en}, 32'd0);
        check("R3 ungating active", {31'd0, clk_active}, 32'd1);
        idle_steps(1, 0);
        check("R4 ungating 2nd", {31'd0, clk_en}, 32'd0);
        idle_steps(1, 0);
        check("R6 running", {31'd0, clk_en}, 32'd1);

        // R7 forced sleep, then gated ignores activity and wake
        step(1, 0, 32'd1, 0, 0, 0, 0);
        idle_steps(3, 0);
        check("R7 gated", {31'd0, clk_active}, 32'd0);
        for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 1, 1, 0);
        check("R7 stays gated", {31'd0, clk_active}, 32'd0);

        // R9 sleep forbidden: activity does not wake, hw wake does
        step(1, 0, 32'd0, 0, 0, 0, 0);
        for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 1, 0, 0);
        check("R9 no wake on activity", {31'd0, clk_active}, 32'd0);
        step(0, 0, 0, 0, 0, 1, 0);
        idle_steps(2, 1);
        check("R9 woken", {31'd0, clk_en}, 32'd1);
        idle_steps(10, 1);
        check("R9 never gates", {31'd0, clk_en}, 32'd1);

        // R11 mode change mid-gating: gating still completes
        step(1, 0, 32'd1, 0, 0, 0, 0);
        idle_steps(1, 0);
        step(1, 0, 32'd2, 0, 0, 0, 0);
        idle_steps(1, 0);
        check("R11 gating completed", {31'd0, clk_active}, 32'd0);
        // R8 forced wake then never gates
        idle_steps(3, 1);
        check("R8 woken", {31'd0, clk_en}, 32'd1);
        idle_steps(10, 1);
        check("R8 never gates", {31'd0, clk_en}, 32'd1);

        // R10 warm reset while gated keeps the domain gated
        step(1, 1, 32'd7, 0, 0, 0, 0);
        step(1, 0, 32'd1, 0, 0, 0, 0);
        idle_steps(4, 0);
        step(0, 0, 0, 0, 0, 0, 1);
        check("R10 mode/act", reg_rdata, 32'h0000_0003);
        reg_addr = 1'b1; #0;
        check("R10 window", reg_rdata, 32'd4);

        // R5 window 0 gates on the first idle cycle
        step(1, 1, 32'd0, 1, 0, 0, 0);
        idle_steps(2, 0);
        check("R5 running before", {31'd0, clk_en}, 32'd1);
        idle_steps(3, 0);
        check("R5 window zero gated", {31'd0, clk_active}, 32'd0);

        // Random phase, model-compared every cycle
        for (int i = 0; i < 4000; i++) begin
            logic wr = ($urandom_range(0, 11) == 0);
            logic a  = $urandom_range(0, 1);
            logic [31:0] wd = $urandom();
            step(wr, a, wd, ($urandom_range(0, 9) == 0),
                 $urandom_range(0, 1), ($urandom_range(0, 39) == 0),
                 ($urandom_range(0, 299) == 0));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule